// File: doc/BRIEF.md
# Crystal Trim and Settle Sequencer

This block orders the start-up of a crystal oscillator once the oscillator is enabled. After the enable it waits a programmable number of ticks from a free-running 250 µs time base. It then drives the stored frequency trim (a 3-bit coarse value and an 8-bit fine value) onto its trim output and reports trim-ready. It then waits a second programmable number of ticks and reports that the crystal has settled. Neither the oscillator nor any register interface is part of the block.

The ticks are not aligned to the enable, so a delay code of N gives a wall-clock wait between (N-1) and N tick periods. A code of zero skips its phase. The two delay codes are held in the block. They are captured from the code inputs on a load strobe and come out of reset as 10 (trim phase) and 2 (settle phase). When the programmed trim changes after start-up, trim-ready drops until the next tick copies the new value to the output.

Top module: `xtal_trim_seq`

## Requirements
- R1: While reset is asserted and right after it, `trim_o` is zero and `trim_ready_o` and `settled_o` are low.
- R2: With a trim-delay code N of 1 or more, the trim value appears and `trim_ready_o` rises on the clock edge that samples the N-th tick after the first edge at which the enable is seen high. A tick that coincides with that first edge is not counted.
- R3: With a settle-delay code M of 1 or more, `settled_o` rises on the clock edge that samples the M-th tick after the edge that applied the trim. Before that edge it stays low.
- R4: A delay code of 0 ends its phase on the next clock edge without any tick: trim is applied two edges after the enable is seen, and the settle phase with code 0 ends one edge after the trim is applied.
- R5: `trim_o` is all zeros until the trim phase ends. It then carries the coarse value in bits 10..8 and the fine value in bits 7..0. The coarse range is 0 (lowest frequency) to 7 (highest), and the fine range is 0x00 (lowest) to 0xFF (highest).
- R6: `trim_ready_o` is high exactly when the enable is high, the trim phase has ended, and `trim_o` equals the programmed coarse and fine values.
- R7: Driving the enable low forces `trim_o`, `trim_ready_o` and `settled_o` to zero in the same cycle, and the sequencer returns to idle at the next edge. While the enable is low, ticks have no effect, and raising the enable again restarts the full trim delay.
- R8: Changing the programmed trim after the trim phase lowers `trim_ready_o` at once. `settled_o` and `trim_o` keep their values until the next tick, which applies the new value and raises `trim_ready_o` again.
- R9: The delay codes come out of reset as trim 10 and settle 2. A high `cfg_load_i` at a clock edge captures both code inputs. Values on the code inputs while `cfg_load_i` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xtal_en_i | input | 1 | Crystal enable; high runs the sequence |
| tick_i | input | 1 | One-cycle pulse from the 250 µs time base |
| cfg_load_i | input | 1 | Captures both delay codes |
| trim_dly_code_i | input | 4 | Trim-phase delay code, in ticks |
| settle_dly_code_i | input | 4 | Settle-phase delay code, in ticks |
| coarse_trim_i | input | 3 | Programmed coarse trim |
| fine_trim_i | input | 8 | Programmed fine trim |
| trim_o | output | 11 | Applied trim {coarse, fine} |
| trim_ready_o | output | 1 | Applied trim matches the programmed trim |
| settled_o | output | 1 | Settle phase complete |

## Verification
The assertions check these every cycle:
- the phase counter never wraps below zero and drops by exactly one per counted tick;
- the applied trim stays zero while idle or in the trim phase;
- the settled state is entered only from the settle phase;
- a dropped enable always leaves the sequencer idle with the trim cleared;
- after the trim phase, the applied trim changes only on a tick.

Only the bench scenarios show the exact tick on which each flag rises for a given code, and the default codes after reset. They also show that unloaded code inputs are ignored, that coarse and fine land at the right bit positions, and how trim-ready behaves when the trim is reprogrammed.

// File: rtl/xts_pkg.sv
`timescale 1ns/1ps
package xts_pkg;
  typedef enum logic [1:0] {
    XS_IDLE        = 2'd0,
    XS_TRIM_WAIT   = 2'd1,
    XS_SETTLE_WAIT = 2'd2,
    XS_SETTLED     = 2'd3
  } xts_state_e;

  function automatic logic trim_is_live(input xts_state_e s);
    return (s == XS_SETTLE_WAIT) || (s == XS_SETTLED);
  endfunction
endpackage

// File: rtl/xts_code_reg.sv
`timescale 1ns/1ps
module xts_code_reg #(
  parameter int W       = 4,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] RST_CODE = W'(RST_VAL);

  always_ff @(posedge clk) begin
    if (!rst_n)      q_o <= RST_CODE;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/xts_phase_timer.sv
`timescale 1ns/1ps
module xts_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         run_i,
  input  logic         tick_i,
  output logic         done_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic         step_w;

  // A phase ends when nothing is left to wait, or when the final tick arrives.
  function automatic logic phase_over(input logic [W-1:0] c, input logic t);
    return (c == '0) || ((c == ONE) && t);
  endfunction

  assign step_w = run_i && tick_i && (cnt_q != '0) && !load_i;
  assign done_o = run_i && phase_over(cnt_q, tick_i);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step_w) cnt_q <= cnt_q - ONE;
  end

  AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0))
    else $error("phase counter wrapped"); // R4

  AST_CNT_ONE_PER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick_i && cnt_q != '0 && !load_i) |=> (cnt_q == $past(cnt_q) - ONE))
    else $error("phase counter skipped a tick"); // R2
endmodule

// File: rtl/xts_trim_hold.sv
`timescale 1ns/1ps
module xts_trim_hold #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) q_o <= '0;
    else if (load_i)     q_o <= d_i;
  end
endmodule

// File: rtl/xtal_trim_seq.sv
`timescale 1ns/1ps
module xtal_trim_seq
  import xts_pkg::*;
#(
  parameter int CODE_W         = 4,
  parameter int COARSE_W       = 3,
  parameter int FINE_W         = 8,
  parameter int TRIM_DLY_RST   = 10,
  parameter int SETTLE_DLY_RST = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         xtal_en_i,
  input  logic                         tick_i,
  input  logic                         cfg_load_i,
  input  logic [CODE_W-1:0]            trim_dly_code_i,
  input  logic [CODE_W-1:0]            settle_dly_code_i,
  input  logic [COARSE_W-1:0]          coarse_trim_i,
  input  logic [FINE_W-1:0]            fine_trim_i,
  output logic [COARSE_W+FINE_W-1:0]   trim_o,
  output logic                         trim_ready_o,
  output logic                         settled_o
);
  localparam int TRIM_W = COARSE_W + FINE_W;

  xts_state_e        st_q, st_n;
  logic [CODE_W-1:0] trim_code_w, settle_code_w, tmr_val_w;
  logic [TRIM_W-1:0] prog_trim_w, app_q;
  logic              tmr_load_w, tmr_run_w, tmr_done_w;
  logic              app_load_w, app_clr_w, mismatch_w;

  // Delay codes, one holding register per phase.
  xts_code_reg #(.W(CODE_W), .RST_VAL(TRIM_DLY_RST)) u_trim_code (
    .clk(clk), .rst_n(rst_n), .load_i(cfg_load_i),
    .d_i(trim_dly_code_i), .q_o(trim_code_w));

  xts_code_reg #(.W(CODE_W), .RST_VAL(SETTLE_DLY_RST)) u_settle_code (
    .clk(clk), .rst_n(rst_n), .load_i(cfg_load_i),
    .d_i(settle_dly_code_i), .q_o(settle_code_w));

  assign prog_trim_w = {coarse_trim_i, fine_trim_i};
  assign mismatch_w  = (app_q != prog_trim_w);
  assign tmr_run_w   = (st_q == XS_TRIM_WAIT) || (st_q == XS_SETTLE_WAIT);

  xts_phase_timer #(.W(CODE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load_w), .load_val_i(tmr_val_w),
    .run_i(tmr_run_w), .tick_i(tick_i), .done_o(tmr_done_w));

  xts_trim_hold #(.W(TRIM_W)) u_trim (
    .clk(clk), .rst_n(rst_n), .clr_i(app_clr_w), .load_i(app_load_w),
    .d_i(prog_trim_w), .q_o(app_q));

  always_comb begin
    st_n       = st_q;
    tmr_load_w = 1'b0;
    tmr_val_w  = '0;
    app_load_w = 1'b0;
    app_clr_w  = 1'b0;
    if (!xtal_en_i) begin
      st_n      = XS_IDLE;
      app_clr_w = 1'b1;
    end else begin
      case (st_q)
        XS_IDLE: begin
          st_n       = XS_TRIM_WAIT;
          tmr_load_w = 1'b1;
          tmr_val_w  = trim_code_w;
          app_clr_w  = 1'b1;
        end
        XS_TRIM_WAIT: begin
          if (tmr_done_w) begin
            st_n       = XS_SETTLE_WAIT;
            tmr_load_w = 1'b1;
            tmr_val_w  = settle_code_w;
            app_load_w = 1'b1;
          end
        end
        XS_SETTLE_WAIT: begin
          if (tmr_done_w) st_n = XS_SETTLED;
          app_load_w = tick_i && mismatch_w;
        end
        default: begin
          app_load_w = tick_i && mismatch_w;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= XS_IDLE;
    else        st_q <= st_n;
  end

  assign trim_o       = xtal_en_i ? app_q : '0;
  assign trim_ready_o = xtal_en_i && trim_is_live(st_q) && !mismatch_w;
  assign settled_o    = xtal_en_i && (st_q == XS_SETTLED);

  AST_ZERO_BEFORE_TRIM: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == XS_IDLE || st_q == XS_TRIM_WAIT) |-> (app_q == '0))
    else $error("trim applied early"); // R5

  AST_SETTLE_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == XS_SETTLED && $past(st_q) != XS_SETTLED) |-> ($past(st_q) == XS_SETTLE_WAIT))
    else $error("settled entered out of order"); // R3

  AST_DROP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !xtal_en_i |=> (st_q == XS_IDLE && app_q == '0))
    else $error("enable drop left state behind"); // R7

  AST_TRIM_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (app_q != $past(app_q)) |->
      (!$past(xtal_en_i) || $past(st_q) == XS_TRIM_WAIT || $past(tick_i)))
    else $error("applied trim changed without a tick"); // R8

  AST_READY_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    trim_ready_o |-> (trim_o == {coarse_trim_i, fine_trim_i}))
    else $error("ready with wrong trim"); // R6
endmodule

// File: tb/xtal_trim_seq_tb_top.sv
`timescale 1ns/1ps
module xtal_trim_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, tick = 1'b0, ld = 1'b0;
  logic [3:0]  tcode = '0, scode = '0;
  logic [2:0]  coarse = '0;
  logic [7:0]  fine = '0;
  logic [10:0] trim;
  logic        rdy, stl;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  xtal_trim_seq dut_i (
    .clk(clk), .rst_n(rst_n), .xtal_en_i(en), .tick_i(tick), .cfg_load_i(ld),
    .trim_dly_code_i(tcode), .settle_dly_code_i(scode),
    .coarse_trim_i(coarse), .fine_trim_i(fine),
    .trim_o(trim), .trim_ready_o(rdy), .settled_o(stl));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    #1;
  endtask

  task automatic outs(input string req, input logic [10:0] t, input logic r, input logic s);
    chk({req, " trim"}, 32'(trim), 32'(t));
    chk({req, " ready"}, 32'(rdy), 32'(r));
    chk({req, " settled"}, 32'(stl), 32'(s));
  endtask

  task automatic start();
    en = 1'b1;
    idle(1);
  endtask

  task automatic stop();
    en = 1'b0;
    #1;
    outs("R7 drop", 11'd0, 1'b0, 1'b0);
    idle(1);
  endtask

  task automatic t_reset();
    outs("R1 reset", 11'd0, 1'b0, 1'b0);
  endtask

  // Default codes: 10 ticks to trim, 2 ticks to settle; ticks spaced out.
  task automatic t_defaults();
    coarse = 3'd5; fine = 8'hA5;
    start();
    for (int i = 0; i < 9; i++) begin pulse(); idle(2); end
    outs("R9 R2 before 10th tick", 11'd0, 1'b0, 1'b0);
    pulse();
    outs("R2 R5 at 10th tick", {3'd5, 8'hA5}, 1'b1, 1'b0);
    pulse();
    outs("R3 one settle tick", {3'd5, 8'hA5}, 1'b1, 1'b0);
    idle(3);
    pulse();
    outs("R3 second settle tick", {3'd5, 8'hA5}, 1'b1, 1'b1);
  endtask

  // Loaded codes trim=3, settle=1 with extreme trim values.
  task automatic t_loaded();
    tcode = 4'd3; scode = 4'd1; ld = 1'b1;
    idle(1);
    ld = 1'b0;
    tcode = 4'd0; scode = 4'd0;
    coarse = 3'd7; fine = 8'hFF;
    start();
    pulse(); pulse();
    outs("R9 unloaded inputs ignored", 11'd0, 1'b0, 1'b0);
    pulse();
    outs("R2 R5 max trim at 3rd tick", 11'h7FF, 1'b1, 1'b0);
    pulse();
    outs("R3 settle after 1 tick", 11'h7FF, 1'b1, 1'b1);
    stop();
  endtask

  // Both codes zero: phases end on clock edges alone.
  task automatic t_zero();
    ld = 1'b1; idle(1); ld = 1'b0;
    coarse = 3'd0; fine = 8'h01;
    en = 1'b1;
    idle(1);
    outs("R4 first edge", 11'd0, 1'b0, 1'b0);
    idle(1);
    outs("R4 trim at second edge", 11'h001, 1'b1, 1'b0);
    idle(1);
    outs("R4 settled at third edge", 11'h001, 1'b1, 1'b1);
  endtask

  // Reprogram trim while settled.
  task automatic t_retrim();
    fine = 8'h40; coarse = 3'd2;
    #1;
    outs("R8 R6 ready drops", 11'h001, 1'b0, 1'b1);
    idle(2);
    outs("R8 held without tick", 11'h001, 1'b0, 1'b1);
    pulse();
    outs("R8 new value on tick", {3'd2, 8'h40}, 1'b1, 1'b1);
    stop();
  endtask

  // Ticks while disabled do nothing; re-enable restarts full delay.
  task automatic t_restart();
    tcode = 4'd2; scode = 4'd1; ld = 1'b1; idle(1); ld = 1'b0;
    pulse(); pulse(); pulse();
    outs("R7 ticks while off", 11'd0, 1'b0, 1'b0);
    start();
    pulse();
    en = 1'b0; #1;
    outs("R7 drop mid phase", 11'd0, 1'b0, 1'b0);
    idle(1);
    start();
    pulse();
    outs("R7 restart not early", 11'd0, 1'b0, 1'b0);
    pulse();
    outs("R7 R2 restart full delay", {3'd2, 8'h40}, 1'b1, 1'b0);
    stop();
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(2);
    t_reset();
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_defaults();
    stop();
    t_loaded();
    t_zero();
    t_retrim();
    t_restart();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule